// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects level-sensitive interrupt sources in groups of eight and gives each group one level output toward a parent interrupt controller. Each source has an enable bit. A group output is high while at least one enabled source of that group is high. The number of groups is a parameter.

Software reaches the enable state and a masked status view through a simple word-addressed register port. Every four consecutive groups share one 32-bit register bank. Each group owns one byte lane of that bank. Enables are changed through two registers, one where written ones set bits and one where written ones clear bits, so no read-modify-write is needed. To find the source to service, software reads the status register and takes the lowest set bit in the group's byte.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0 and `reg_rdata` is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose `reg_wdata` bit is 1. Bits written 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose `reg_wdata` bit is 1. Bits written 0 keep their value.
- R4: A read of offset 0x0 or 0x4 returns the bank's 32 enable bits on `reg_rdata` in the cycle after `reg_rd_en`. `reg_rdata` holds its value while no read is made.
- R5: A read of offset 0xC returns, for all 32 sources of the bank, the source level ANDed with its enable bit, as sampled in the read cycle.
- R6: Output `group_irq[g]` is registered. In the cycle after a clock edge it equals the OR of the eight sources of group g ANDed with their enables, both as they stood before that edge.
- R7: Group g uses bank g/4, whose base byte address is (g/4)*0x10. Within that bank it uses bits (g mod 4)*8 to (g mod 4)*8+7. Source s of group g is `irq_src[g*8+s]`.
- R8: A write to offset 0xC or 0x8, to a bank index at or above the number of banks, or to an address whose two low bits are not 0 leaves all enables unchanged. A read of any such address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | NUM_GROUPS*8 | Level interrupt sources, eight per group |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| group_irq | output | NUM_GROUPS | One level interrupt per group |

## Verification
The assertions assume that `reg_wr_en` and `reg_rd_en` are never both high in the same cycle. They also assume that `irq_src` only changes between clock edges and is never X once reset is released. The bench drives all inputs on the falling clock edge and issues one register operation at a time. Its random stimulus writes set and clear masks to mapped and unmapped banks, reads every offset, and redraws the source vector. Its directed cases cover reset, the zero-bit cases of set and clear, ignored writes to the status and reserved offsets, and the byte-lane placement of a group in the second bank.

// File: rtl/irq_cmb_pkg.sv
package irq_cmb_pkg;
  localparam int SRC_PER_GRP  = 8;
  localparam int GRP_PER_BANK = 4;
  localparam int BANK_W       = SRC_PER_GRP * GRP_PER_BANK;

  typedef enum logic [1:0] {
    RSEL_SET  = 2'd0,
    RSEL_CLR  = 2'd1,
    RSEL_RSV  = 2'd2,
    RSEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_cmb_rst_sync.sv
module irq_cmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_cmb_decode.sv
module irq_cmb_decode
  import irq_cmb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [BIDX_W-1:0] bank_idx,
  output logic              bank_hit,
  output reg_sel_e          sel,
  output logic [NUM_BANKS-1:0] set_we,
  output logic [NUM_BANKS-1:0] clr_we
);
  always_comb begin
    bank_idx = addr[ADDR_W-1:4];
    sel      = reg_sel_e'(addr[3:2]);
    bank_hit = (addr[1:0] == 2'b00) &&
               ({{(32-BIDX_W){1'b0}}, bank_idx} < 32'(NUM_BANKS));
    set_we   = '0;
    clr_we   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_en && bank_hit && (bank_idx == BIDX_W'(b))) begin
        set_we[b] = (sel == RSEL_SET);
        clr_we[b] = (sel == RSEL_CLR);
      end
    end
  end
endmodule

// File: rtl/irq_cmb_en_bank.sv
module irq_cmb_en_bank
  import irq_cmb_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q
);
  logic [BANK_W-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_ce = set_we | clr_we;
    en_d  = en_q;
    if (set_we) en_d = en_d | wdata;
    if (clr_we) en_d = en_d & ~wdata;
    en_d  = en_d & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/irq_cmb_group_or.sv
module irq_cmb_group_or
  import irq_cmb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_PER_GRP-1:0] src,
  input  logic [SRC_PER_GRP-1:0] en,
  output logic                   irq_q
);
  logic irq_d;

  always_comb irq_d = |(src & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_cmb_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] irq_src,
  input  logic                              reg_wr_en,
  input  logic                              reg_rd_en,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [BANK_W-1:0]                 reg_wdata,
  output logic [BANK_W-1:0]                 reg_rdata,
  output logic [NUM_GROUPS-1:0]             group_irq
);
  localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;
  localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int PAD_W     = NUM_BANKS * BANK_W;
  localparam int BIDX_W    = ADDR_W - 4;

  logic                 rst_i_n;
  logic [BIDX_W-1:0]    bank_idx;
  logic                 bank_hit;
  reg_sel_e             sel;
  logic [NUM_BANKS-1:0] set_we;
  logic [NUM_BANKS-1:0] clr_we;
  logic [PAD_W-1:0]     en_all;
  logic [PAD_W-1:0]     src_pad;
  logic [NUM_SRC-1:0]   en_flat;
  logic [BANK_W-1:0]    bank_en;
  logic [BANK_W-1:0]    bank_src;
  logic [BANK_W-1:0]    rdata_d;

  irq_cmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  irq_cmb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr     (reg_addr),
    .wr_en    (reg_wr_en),
    .bank_idx (bank_idx),
    .bank_hit (bank_hit),
    .sel      (sel),
    .set_we   (set_we),
    .clr_we   (clr_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int VALID = ((NUM_SRC - b*BANK_W) >= BANK_W) ? BANK_W
                                                           : (NUM_SRC - b*BANK_W);
    localparam logic [BANK_W-1:0] MASK = (VALID == BANK_W) ? {BANK_W{1'b1}}
                                         : BANK_W'((64'd1 << VALID) - 64'd1);
    irq_cmb_en_bank #(.IMPL_MASK(MASK)) u_en (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .wdata  (reg_wdata),
      .en_q   (en_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = irq_src;
  end

  assign en_flat = en_all[NUM_SRC-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_cmb_group_or u_or (
      .clk   (clk),
      .rst_n (rst_i_n),
      .src   (irq_src[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .en    (en_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .irq_q (group_irq[g])
    );
  end

  always_comb begin
    bank_en  = '0;
    bank_src = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BIDX_W'(b)) begin
        bank_en  = en_all[b*BANK_W +: BANK_W];
        bank_src = src_pad[b*BANK_W +: BANK_W];
      end
    end
    rdata_d = '0;
    if (bank_hit) begin
      unique case (sel)
        RSEL_SET, RSEL_CLR: rdata_d = bank_en;
        RSEL_STAT:          rdata_d = bank_en & bank_src;
        default:            rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rdata_d;
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_GROUPS*8-1:0] irq_src,
  input logic                    reg_wr_en,
  input logic                    reg_rd_en,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [31:0]             reg_rdata,
  input logic [NUM_GROUPS-1:0]   group_irq,
  input logic [NUM_GROUPS*8-1:0] en_q
);
  AST_EN_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(en_q)); // R2

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr[3:2] == 2'b11) |=> $stable(en_q)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata)); // R4

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr[3:2] == 2'b10) |=> (reg_rdata == 32'd0)); // R8

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_GROUP_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_src[g*8 +: 8] & en_q[g*8 +: 8])) |=> group_irq[g]); // R6
    AST_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(irq_src[g*8 +: 8] & en_q[g*8 +: 8])) |=> !group_irq[g]); // R6
  end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_src   (irq_src),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .group_irq (group_irq),
  .en_q      (en_flat)
);

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;
  localparam int NG = 8;
  localparam int NS = NG * 8;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_src;
  logic          reg_wr_en, reg_rd_en;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NG-1:0] group_irq;

  logic [NS-1:0] en_m;
  int            n_chk = 0;
  int            n_bad = 0;

  always #10 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .group_irq(group_irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int bk = int'(a[7:4]);
    if (a[1:0] != 2'b00 || bk >= NB) return 32'd0;
    case (a[3:2])
      2'd0, 2'd1: return en_m[bk*32 +: 32];
      2'd3:       return en_m[bk*32 +: 32] & irq_src[bk*32 +: 32];
      default:    return 32'd0;
    endcase
  endfunction

  function automatic logic [NG-1:0] exp_groups();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |(irq_src[g*8 +: 8] & en_m[g*8 +: 8]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int bk = int'(a[7:4]);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a[1:0] == 2'b00 && bk < NB) begin
      if (a[3:2] == 2'd0) en_m[bk*32 +: 32] = en_m[bk*32 +: 32] | d;
      if (a[3:2] == 2'd1) en_m[bk*32 +: 32] = en_m[bk*32 +: 32] & ~d;
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    logic [31:0] e = exp_read(a);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(req, reg_rdata, e);
  endtask

  task automatic chk_groups(input string req);
    logic [NG-1:0] e = exp_groups();
    @(negedge clk);
    check(req, 32'(group_irq), 32'(e));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0b));
    rst_n = 1'b0; irq_src = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_addr = '0; reg_wdata = '0; en_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 32'd0);
    check("R1 groups", 32'(group_irq), 32'd0);
    irq_src = '1;
    chk_groups("R1 groups disabled");
    rd("R1 enables", 8'h00);
    rd("R1 enables bank1", 8'h10);

    // R2 set, zeros no effect
    wr(8'h00, 32'h0000_00A5);
    wr(8'h00, 32'h0000_0000);
    rd("R2 set", 8'h04);
    // R3 clear, zeros no effect
    wr(8'h04, 32'h0000_0021);
    wr(8'h04, 32'h0000_0000);
    rd("R3 clear", 8'h00);
    // R4 hold without read
    repeat (3) @(negedge clk);
    check("R4 hold", reg_rdata, 32'h0000_0084);

    // R7 group 5 -> bank 1, byte lane 1
    irq_src = '0;
    irq_src[5*8 + 3] = 1'b1;
    wr(8'h10, 32'h0000_0800);
    chk_groups("R7 group5");
    check("R7 group5 bit", 32'(group_irq[5]), 32'd1);
    rd("R5 status bank1", 8'h1C);
    rd("R7 status bank0", 8'h0C);

    // R8 ignored writes and zero reads
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd("R8 enables unchanged", 8'h00);
    rd("R8 enables unchanged bank1", 8'h14);
    rd("R8 reserved reads zero", 8'h08);
    rd("R8 unmapped bank zero", 8'h20);
    rd("R8 misaligned zero", 8'h12);

    // R6 source drop deasserts output
    irq_src = '0;
    chk_groups("R6 drop");

    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 4);
      logic [7:0] a;
      a = {4'($urandom % 3), 2'($urandom % 4), 2'b00};
      case (op)
        0: wr({a[7:4], 4'h0}, $urandom);
        1: wr({a[7:4], 4'h4}, $urandom);
        2: rd("R5 random read", a);
        default: begin
          irq_src = {$urandom, $urandom};
          chk_groups("R6 random groups");
        end
      endcase
    end
    chk_groups("R6 final groups");
    rd("R5 final status", 8'h0C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule